// File: doc/BRIEF.md
# Shared-Prescaler Multi-Channel Down-Counting Timer

The block provides a small bank of down-counting timers that all advance on a common time base. A single prescaler counts down on every clock cycle; each time it passes zero it reloads itself from a programmable reload word and emits a one-cycle tick. Every enabled timer channel moves down by one on that tick. When a channel passes zero it either restarts from its own reload word or stops and disables itself, as its control word selects. If its interrupt enable is set, it raises a one-cycle interrupt pulse.

Software reaches all state through a word-addressed register bus. Writes take effect at the clock edge and reads are combinational. The lowest four words hold the shared prescaler state and a configuration word. Each channel owns a four-word slot after them. A self-clearing load bit in each control word presets that channel's counter from its reload word.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every counter, reload word, control word and the prescaler value and reload read as zero, and no interrupt is asserted.
- R2: The prescaler decrements once per clock. In a cycle where it is zero, the next edge reloads it from the prescaler reload word and that cycle is a tick, so a tick occurs every reload+1 clocks.
- R3: An enabled channel decrements by one on each tick and holds between ticks. A channel whose enable bit (control bit 0) is clear holds its counter.
- R4: With the restart bit (control bit 1) set, a channel at zero reloads from its reload word on the next tick. Its interrupt period is therefore (prescaler reload+1)*(channel reload+1) clocks.
- R5: With the restart bit clear, a channel at zero clears its own enable bit on the next tick and its counter stays at zero.
- R6: Writing the control word with bit 2 set copies the reload word into the counter. Writing it with bit 2 clear leaves the counter unchanged. Bit 2 always reads back as zero.
- R7: When a channel passes zero and its interrupt-enable bit (control bit 3) is set, its interrupt output goes high for exactly one clock. With bit 3 clear, no pulse occurs.
- R8: The bus uses word addresses. Word 0 is the prescaler value, word 1 the prescaler reload, and word 2 the configuration word, whose low 3 bits read NCH-1. Word 3 reads zero. Channel n uses word 4+4n for its counter, 5+4n for its reload, 6+4n for its control and 7+4n, which reads zero. Slots beyond NCH read zero and ignore writes.
- R9: A bus write to a channel's counter or control word, or to the prescaler value, in a given cycle takes precedence over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | NCH | One-cycle interrupt pulse per channel |

## Verification
The bench sweeps every combination of small prescaler and channel reload values and compares the measured interrupt spacing with the product (P+1)*(T+1). A design that reloaded one cycle late, or that treated zero as the last count, would be off by one factor in that product. A separate pass checks each channel slot, which catches a wrong slot decode. The stop-at-zero case must give exactly one pulse and a cleared enable bit; a design that kept counting would wrap and fire again. Other checks cover a load bit written as zero, a disabled channel under ticks, and a counter write racing a tick. These expose designs that load unconditionally, count while disabled, or let counting override software.

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 12,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq
);
  localparam int SW = AW - 2;

  logic [PW-1:0] presc, prld;
  logic          tick;
  logic [NCH-1:0][CW-1:0] cnt, rld;
  logic [NCH-1:0] en, rl, ie;

  wire [SW-1:0] slot = bus_addr[AW-1:2];
  wire [1:0]    word = bus_addr[1:0];
  wire wr_pv = bus_we && slot == '0 && word == 2'd0;
  wire wr_pr = bus_we && slot == '0 && word == 2'd1;

  assign tick = (presc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      prld  <= '0;
    end else begin
      if (wr_pr) prld <= bus_wdata[PW-1:0];
      if (wr_pv)      presc <= bus_wdata[PW-1:0];
      else if (tick)  presc <= prld;
      else            presc <= presc - 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [SW-1:0] MYSLOT = SW'(g + 1);
    logic [CW-1:0] c, r;
    logic e, l, i, q;
    wire sel     = bus_we && slot == MYSLOT;
    wire wr_cnt  = sel && word == 2'd0;
    wire wr_rld  = sel && word == 2'd1;
    wire wr_ctrl = sel && word == 2'd2;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c <= '0; r <= '0; e <= 1'b0; l <= 1'b0; i <= 1'b0; q <= 1'b0;
      end else begin
        q <= 1'b0;
        if (wr_rld) r <= bus_wdata[CW-1:0];
        if (wr_ctrl) begin
          e <= bus_wdata[0];
          l <= bus_wdata[1];
          i <= bus_wdata[3];
        end
        if (wr_cnt)
          c <= bus_wdata[CW-1:0];
        else if (wr_ctrl && bus_wdata[2])
          c <= r;
        else if (tick && e && !wr_ctrl) begin
          if (c == '0) begin
            q <= i;
            if (l) c <= r;
            else   e <= 1'b0;
          end else begin
            c <= c - 1'b1;
          end
        end
      end
    end

    assign cnt[g] = c;
    assign rld[g] = r;
    assign en[g]  = e;
    assign rl[g]  = l;
    assign ie[g]  = i;
    assign irq[g] = q;
  end

  always_comb begin
    bus_rdata = '0;
    if (slot == '0) begin
      case (word)
        2'd0:    bus_rdata = 32'(presc);
        2'd1:    bus_rdata = 32'(prld);
        2'd2:    bus_rdata = 32'(NCH - 1) & 32'h7;
        default: bus_rdata = '0;
      endcase
    end
    for (int k = 0; k < NCH; k++) begin
      if (slot == SW'(k + 1)) begin
        case (word)
          2'd0:    bus_rdata = 32'(cnt[k]);
          2'd1:    bus_rdata = 32'(rld[k]);
          2'd2:    bus_rdata = {28'd0, ie[k], 1'b0, rl[k], en[k]};
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 12,
  parameter int AW  = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic                   tick,
  input logic [PW-1:0]          presc,
  input logic [PW-1:0]          prld,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] rld,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         rl,
  input logic [NCH-1:0]         ie,
  input logic [NCH-1:0]         irq
);
  p_presc_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bus_we) |=> presc == $past(prld));
  p_presc_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_we) |=> presc == $past(presc) - 1'b1);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_we) |=> $stable(cnt[g]));
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en[g] && rl[g] && cnt[g] == '0 && !bus_we) |=> cnt[g] == $past(rld[g]));
    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en[g] && !rl[g] && cnt[g] == '0 && !bus_we) |=> (!en[g] && cnt[g] == '0));
    p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> $past(ie[g]));
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> $past(tick && en[g] && cnt[g] == '0));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) i_chk (.*);

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;
  localparam int NCH = 4;
  localparam int AW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer_bank #(.NCH(NCH), .AW(AW)) i_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #0.5;
    d = bus_rdata;
  endtask

  task automatic count_irq(input int ch, input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (irq[ch]) n++;
    end
  endtask

  task automatic period(input int ch, input int p, input int t);
    int base = 4 + 4 * ch;
    int k;
    int exp = (p + 1) * (t + 1);
    wr(base + 2, 0);
    wr(1, p);
    wr(0, p);
    wr(base + 1, t);
    wr(base + 2, 32'hF);
    k = 0;
    while (!irq[ch] && k < 1000) begin @(negedge clk); k++; end
    k = 0;
    do begin @(negedge clk); k++; end while (!irq[ch] && k < 1000);
    chk($sformatf("R4 period ch%0d P=%0d T=%0d", ch, p, t), k, exp);
    if (exp > 1) begin
      @(negedge clk);
      chk("R7 pulse width", {31'd0, irq[ch]}, 0);
    end
    wr(base + 2, 0);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, v); chk("R1 prescaler value", v, 0);
    rd(1, v); chk("R1 prescaler reload", v, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(4 + 4*c, v); chk("R1 counter", v, 0);
      rd(5 + 4*c, v); chk("R1 reload", v, 0);
      rd(6 + 4*c, v); chk("R1 control", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);

    rd(2, v); chk("R8 config word", v, NCH - 1);
    rd(3, v); chk("R8 spare word", v, 0);
    rd(7, v); chk("R8 channel spare word", v, 0);
    wr(4 + 4*NCH, 123);
    rd(4 + 4*NCH, v); chk("R8 absent slot", v, 0);
    wr(10, 32'h8);
    rd(10, v); chk("R8 ch1 control field", v, 8);
    wr(10, 0);

    wr(1, 3); wr(0, 3);
    rd(0, v); chk("R2 prescaler 3", v, 3);
    @(negedge clk); rd(0, v); chk("R2 prescaler 2", v, 2);
    @(negedge clk); rd(0, v); chk("R2 prescaler 1", v, 1);
    @(negedge clk); rd(0, v); chk("R2 prescaler 0", v, 0);
    @(negedge clk); rd(0, v); chk("R2 prescaler reload", v, 3);

    wr(1, 0); wr(0, 0);
    wr(5, 5); wr(6, 32'h4);
    rd(4, v); chk("R6 load copies reload", v, 5);
    repeat (10) @(negedge clk);
    rd(4, v); chk("R3 disabled holds", v, 5);
    wr(6, 32'h1);
    rd(4, v); chk("R3 enable write cycle", v, 5);
    @(negedge clk); rd(4, v); chk("R3 decrement", v, 4);
    @(negedge clk); rd(4, v); chk("R3 decrement", v, 3);
    repeat (10) @(negedge clk);
    rd(4, v); chk("R5 stopped at zero", v, 0);
    rd(6, v); chk("R5 enable cleared", v, 0);

    wr(5, 2); wr(6, 32'hD);
    count_irq(0, 20, n); chk("R5 R7 single pulse in stop mode", n, 1);
    rd(6, v); chk("R5 control after stop", v, 8);
    rd(4, v); chk("R5 counter after stop", v, 0);

    wr(6, 0); wr(4, 7); wr(5, 9); wr(6, 0);
    rd(4, v); chk("R6 load bit zero no effect", v, 7);
    wr(6, 32'h4);
    rd(4, v); chk("R6 load bit one", v, 9);
    rd(6, v); chk("R6 load bit reads zero", v, 0);

    wr(5, 50); wr(6, 32'h7);
    wr(4, 100);
    rd(4, v); chk("R9 write beats tick", v, 100);
    wr(6, 0);

    wr(5, 1); wr(6, 32'h7);
    count_irq(0, 20, n); chk("R7 no pulse with ie clear", n, 0);
    wr(6, 0);

    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 4; t++)
        period(0, p, t);
    for (int c = 1; c < NCH; c++)
      period(c, 1, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule